// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block takes one DMA read or write at a time, described by a start byte address, a byte count and, for writes, the bytes to store. It walks the transfer as a series of transactions on a downstream port, none of which crosses a cache-line boundary. Only the first transaction can start partway into a line. It is cut short at the end of that line, so every later transaction starts on a line boundary and carries up to one full line.

The downstream side answers each transaction with a completion pulse. For a store it is only an acknowledgement. For a load it also carries the whole addressed line, and the sequencer pulls the wanted bytes out of that line into a response buffer. When the last byte has completed, the engine goes idle. One cycle later it gives the requester a single response, if the requester asked for one.

A request that arrives while a transfer is in flight is turned away with a full status. The block remembers that it turned someone away and sends a retry pulse in the cycle it goes idle. A request presented during that pulse is taken at once. A drain input makes the block report when nothing is outstanding, and it also pulses at the moment the outstanding transfer finishes.

Top module: `dma_line_sequencer`

## Requirements
- R1: While a transfer is outstanding, a request with req_valid high gets a one-cycle req_full pulse in the next cycle. It is not accepted and causes no downstream transaction.
- R2: After any request has been turned away with req_full, the cycle that follows the final completion of the active transfer shows a one-cycle retry pulse. The remembered rejection is then cleared, so a later transfer ends without a retry.
- R3: The first transaction's dn_addr is the start address. Its dn_len is the full length when the in-line offset (address bits below log2 of LINE_BYTES) plus the length is at most LINE_BYTES. Otherwise dn_len is LINE_BYTES minus the offset.
- R4: Every later transaction's dn_addr is the start address plus the bytes already completed, which is line-aligned. Its dn_len is the smaller of the remaining bytes and LINE_BYTES.
- R5: dn_store is 1 for a write and 0 for a read. In a store transaction, request byte k lands in dn_wdata byte lane (start offset + k) for the first transaction, and in lane (k − bytes completed) for later ones.
- R6: The next transaction appears on dn_valid in the cycle after a non-final completion. After the final completion dn_valid stays low.
- R7: For a read, rsp_rdata byte i (i below the length) holds the byte at start address + i. For the first transaction it is taken from the returned line at the start offset, and for later transactions from lane 0 onward.
- R8: The engine is idle in the cycle that shows the retry pulse, so a request presented during that pulse is accepted: req_accept is high and a transaction is issued in the next cycle.
- R9: When req_need_rsp was high, rsp_valid pulses for one cycle, two cycles after the edge that samples the final completion, with rsp_write equal to the direction. When req_need_rsp was low, no response is given.
- R10: drained is high exactly when drain_req is high and no transfer is outstanding. drain_done pulses for one cycle when a transfer finishes while drain_req is high.
- R11: A request whose length is 0 or above MAX_LEN, presented while idle, gets a one-cycle req_badlen pulse. It is not accepted, issues nothing and arms no retry.
- R12: After reset no transfer is outstanding, and dn_valid, rsp_valid, retry, req_accept, req_full, req_badlen and drain_done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_need_rsp | input | 1 | Requester wants a response |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_wdata | input | MAX_LEN*8 | Write bytes, byte k in bits [8k+7:8k] |
| req_accept | output | 1 | Request taken (one cycle later) |
| req_full | output | 1 | Request turned away, engine busy |
| req_badlen | output | 1 | Request turned away, bad length |
| retry | output | 1 | Engine freed after a rejection |
| dn_valid | output | 1 | Downstream transaction pulse |
| dn_store | output | 1 | 1 = store, 0 = load |
| dn_addr | output | ADDR_W | Transaction byte address |
| dn_len | output | CL_W | Transaction byte count |
| dn_wdata | output | LINE_BYTES*8 | Store bytes in line lanes |
| cpl_valid | input | 1 | Completion of the outstanding transaction |
| cpl_data | input | LINE_BYTES*8 | Whole line for a load completion |
| rsp_valid | output | 1 | Response pulse |
| rsp_write | output | 1 | Direction of the finished transfer |
| rsp_rdata | output | MAX_LEN*8 | Read bytes, byte i at bits [8i+7:8i] |
| drain_req | input | 1 | Drain requested |
| drained | output | 1 | Drain requested and nothing outstanding |
| drain_done | output | 1 | Transfer finished during a drain |

## Verification
The bench builds the block with LINE_BYTES = 16, MAX_LEN = 64 and ADDR_W = 16. The short line lets a maximum-length transfer span up to five transactions. Cases within reach include a head chunk clipped at every offset, a transfer that ends exactly on a line edge, a single byte in a line's last lane, and a length one past the limit. With the small response buffer, placement of the final byte at the buffer's top end can be checked directly.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_TAKE   = 2'd1,
    VERD_FULL   = 2'd2,
    VERD_BADLEN = 2'd3
  } verdict_e;

  // Busy wins over a bad length: a busy engine answers full regardless.
  function automatic verdict_e judge(input logic valid, input logic busy,
                                     input logic len_zero, input logic len_big);
    if (!valid)                return VERD_NONE;
    else if (busy)             return VERD_FULL;
    else if (len_zero || len_big) return VERD_BADLEN;
    else                       return VERD_TAKE;
  endfunction

endpackage

// File: rtl/dls_chunker.sv
module dls_chunker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 9
) (
  input  logic [ADDR_W-1:0]                 start,
  input  logic [LEN_W-1:0]                  total,
  input  logic [LEN_W-1:0]                  done,
  output logic [ADDR_W-1:0]                 chunk_addr,
  output logic [$clog2(LINE_BYTES)-1:0]     chunk_off,
  output logic [$clog2(LINE_BYTES):0]       chunk_len,
  output logic                              chunk_first
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CL_W  = OFF_W + 1;
  localparam int W     = LEN_W + 1;

  // Head chunk: whole request if it fits in the line, else up to the line end.
  function automatic logic [CL_W-1:0] head_len(input logic [OFF_W-1:0] off,
                                               input logic [LEN_W-1:0] tot);
    if (W'(off) + W'(tot) <= W'(LINE_BYTES)) return CL_W'(tot);
    else return CL_W'(W'(LINE_BYTES) - W'(off));
  endfunction

  // Later chunks: whichever is smaller, the remainder or one line.
  function automatic logic [CL_W-1:0] tail_len(input logic [LEN_W-1:0] rem);
    if (W'(rem) < W'(LINE_BYTES)) return CL_W'(rem);
    else return CL_W'(LINE_BYTES);
  endfunction

  always_comb begin
    chunk_first = (done == '0);
    chunk_addr  = start + ADDR_W'(done);
    chunk_off   = chunk_first ? start[OFF_W-1:0] : '0;
    chunk_len   = chunk_first ? head_len(start[OFF_W-1:0], total)
                              : tail_len(total - done);
  end
endmodule

// File: rtl/dls_wpack.sv
module dls_wpack #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int LEN_W      = 9
) (
  input  logic [MAX_LEN*8-1:0]              wdata,
  input  logic [LEN_W-1:0]                  done,
  input  logic [$clog2(LINE_BYTES)-1:0]     off,
  input  logic [$clog2(LINE_BYTES):0]       clen,
  output logic [LINE_BYTES*8-1:0]           line
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CL_W  = OFF_W + 1;
  localparam int LW    = LINE_BYTES * 8;

  logic [MAX_LEN*8-1:0] shifted;
  logic [LW-1:0]        seg;

  always_comb begin
    shifted = wdata >> {done, 3'b000};
    for (int b = 0; b < LINE_BYTES; b++) begin
      seg[b*8 +: 8] = (CL_W'(b) < clen) ? shifted[b*8 +: 8] : 8'h00;
    end
    // Nonzero offset only on the head chunk, where offset + length fits the line.
    line = seg << {off, 3'b000};
  end
endmodule

// File: rtl/dls_rbuf.sv
module dls_rbuf #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int LEN_W      = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_en,
  input  logic [LINE_BYTES*8-1:0]           line_in,
  input  logic [$clog2(LINE_BYTES)-1:0]     off,
  input  logic [LEN_W-1:0]                  done,
  input  logic [$clog2(LINE_BYTES):0]       clen,
  output logic [MAX_LEN*8-1:0]              hold
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CL_W  = OFF_W + 1;
  localparam int LW    = LINE_BYTES * 8;
  localparam int BW    = MAX_LEN * 8;

  logic [LW-1:0] ext, lbytes, lmask;
  logic [BW-1:0] placed, wmask;

  always_comb begin
    ext = line_in >> {off, 3'b000};
    for (int b = 0; b < LINE_BYTES; b++) begin
      lmask[b*8 +: 8]  = (CL_W'(b) < clen) ? 8'hFF : 8'h00;
      lbytes[b*8 +: 8] = ext[b*8 +: 8] & lmask[b*8 +: 8];
    end
    placed = BW'(lbytes) << {done, 3'b000};
    wmask  = BW'(lmask)  << {done, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hold <= '0;
    else if (load_en) hold <= (hold & ~wmask) | (placed & wmask);
  end

  AST_RBUF_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (int'(done) + int'(clen) <= MAX_LEN)); // R7
endmodule

// File: rtl/dma_line_sequencer.sv
module dma_line_sequencer #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CL_W      = OFF_W + 1,
  localparam int LW        = LINE_BYTES * 8,
  localparam int BW        = MAX_LEN * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_need_rsp,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BW-1:0]     req_wdata,
  output logic              req_accept,
  output logic              req_full,
  output logic              req_badlen,
  output logic              retry,
  output logic              dn_valid,
  output logic              dn_store,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [CL_W-1:0]   dn_len,
  output logic [LW-1:0]     dn_wdata,
  input  logic              cpl_valid,
  input  logic [LW-1:0]     cpl_data,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [BW-1:0]     rsp_rdata,
  input  logic              drain_req,
  output logic              drained,
  output logic              drain_done
);
  import dls_pkg::*;

  localparam int SW = CL_W + 1;

  // Transfer state
  logic              busy, r_write, r_need, pend_retry, fin_q, dn_first;
  logic [ADDR_W-1:0] r_start;
  logic [LEN_W-1:0]  r_total, r_issued, r_cdone;
  logic [BW-1:0]     r_wdata;
  logic [OFF_W-1:0]  r_coff;
  logic [CL_W-1:0]   r_clen;

  // Chunker inputs: the live request when idle, the stored transfer when busy
  logic [ADDR_W-1:0] sel_start;
  logic [LEN_W-1:0]  sel_total, sel_done;
  logic [BW-1:0]     sel_wdata;
  logic              sel_write;

  logic [ADDR_W-1:0] c_addr;
  logic [OFF_W-1:0]  c_off;
  logic [CL_W-1:0]   c_len;
  logic              c_first;
  logic [LW-1:0]     w_line;

  // Named events
  verdict_e verdict;
  logic     take_evt, rej_evt, bad_evt, cpl_evt, fin_evt, step_evt, issue_evt;

  always_comb begin
    sel_start = busy ? r_start  : req_addr;
    sel_total = busy ? r_total  : req_len;
    sel_done  = busy ? r_issued : '0;
    sel_wdata = busy ? r_wdata  : req_wdata;
    sel_write = busy ? r_write  : req_write;

    verdict   = judge(req_valid, busy, req_len == '0, req_len > LEN_W'(MAX_LEN));
    take_evt  = (verdict == VERD_TAKE);
    rej_evt   = (verdict == VERD_FULL);
    bad_evt   = (verdict == VERD_BADLEN);
    cpl_evt   = busy && cpl_valid;
    fin_evt   = cpl_evt && (r_issued == r_total);
    step_evt  = cpl_evt && !fin_evt;
    issue_evt = take_evt || step_evt;
  end

  dls_chunker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) u_chunk (
    .start(sel_start), .total(sel_total), .done(sel_done),
    .chunk_addr(c_addr), .chunk_off(c_off), .chunk_len(c_len), .chunk_first(c_first)
  );

  dls_wpack #(.LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_wpack (
    .wdata(sel_wdata), .done(sel_done), .off(c_off), .clen(c_len), .line(w_line)
  );

  dls_rbuf #(.LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .load_en(cpl_evt && !r_write), .line_in(cpl_data),
    .off(r_coff), .done(r_cdone), .clen(r_clen), .hold(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; r_write <= 1'b0; r_need <= 1'b0; pend_retry <= 1'b0;
      fin_q <= 1'b0; dn_first <= 1'b0;
      r_start <= '0; r_total <= '0; r_issued <= '0; r_cdone <= '0;
      r_wdata <= '0; r_coff <= '0; r_clen <= '0;
      req_accept <= 1'b0; req_full <= 1'b0; req_badlen <= 1'b0; retry <= 1'b0;
      dn_valid <= 1'b0; dn_store <= 1'b0; dn_addr <= '0; dn_len <= '0; dn_wdata <= '0;
      rsp_valid <= 1'b0; rsp_write <= 1'b0; drain_done <= 1'b0;
    end else begin
      req_accept <= take_evt;
      req_full   <= rej_evt;
      req_badlen <= bad_evt;
      dn_valid   <= issue_evt;
      retry      <= 1'b0;
      drain_done <= 1'b0;
      fin_q      <= fin_evt;
      rsp_valid  <= fin_q && r_need;
      if (fin_q) rsp_write <= r_write;

      if (take_evt) begin
        busy     <= 1'b1;
        r_write  <= req_write;
        r_need   <= req_need_rsp;
        r_start  <= req_addr;
        r_total  <= req_len;
        r_wdata  <= req_wdata;
        r_issued <= LEN_W'(c_len);
      end
      if (step_evt) r_issued <= r_issued + LEN_W'(c_len);

      if (issue_evt) begin
        dn_store <= sel_write;
        dn_addr  <= c_addr;
        dn_len   <= c_len;
        dn_wdata <= w_line;
        dn_first <= c_first;
        r_cdone  <= sel_done;
        r_coff   <= c_off;
        r_clen   <= c_len;
      end

      // Busy drops on the same edge that raises retry, so a retried request is taken at once.
      if (fin_evt) begin
        busy       <= 1'b0;
        retry      <= pend_retry || rej_evt;
        pend_retry <= 1'b0;
        drain_done <= drain_req;
      end else if (rej_evt) begin
        pend_retry <= 1'b1;
      end
    end
  end

  assign drained = drain_req && !busy;

  AST_FULL_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_evt && !cpl_evt) |=> !dn_valid); // R1
  AST_RETRY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !busy); // R8
  AST_HEAD_FITS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_len != '0) &&
      (SW'(dn_addr[OFF_W-1:0]) + SW'(dn_len) <= SW'(LINE_BYTES))); // R3
  AST_TAIL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_first) |-> (dn_addr[OFF_W-1:0] == '0)); // R4
  AST_RSP_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(fin_evt, 2)); // R9
  AST_DRAIN_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> drained); // R10
  AST_BADLEN_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    req_badlen |-> !dn_valid && !req_accept); // R11
endmodule

// File: tb/dma_line_sequencer_test.sv
module dma_line_sequencer_test;
  localparam int ADDR_W = 16;
  localparam int LINE   = 16;
  localparam int MAXL   = 64;
  localparam int LEN_W  = $clog2(MAXL + 1);
  localparam int CL_W   = $clog2(LINE) + 1;
  localparam int BW     = MAXL * 8;
  localparam int LW     = LINE * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_need_rsp = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [BW-1:0]     req_wdata = '0;
  logic req_accept, req_full, req_badlen, retry;
  logic dn_valid, dn_store;
  logic [ADDR_W-1:0] dn_addr;
  logic [CL_W-1:0]   dn_len;
  logic [LW-1:0]     dn_wdata;
  logic cpl_valid = 0;
  logic [LW-1:0] cpl_data = '0;
  logic rsp_valid, rsp_write;
  logic [BW-1:0] rsp_rdata;
  logic drain_req = 0, drained, drain_done;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  dma_line_sequencer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .MAX_LEN(MAXL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_need_rsp(req_need_rsp), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .req_accept(req_accept), .req_full(req_full),
    .req_badlen(req_badlen), .retry(retry), .dn_valid(dn_valid), .dn_store(dn_store),
    .dn_addr(dn_addr), .dn_len(dn_len), .dn_wdata(dn_wdata), .cpl_valid(cpl_valid),
    .cpl_data(cpl_data), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
    .rsp_rdata(rsp_rdata), .drain_req(drain_req), .drained(drained),
    .drain_done(drain_done)
  );

  // Stimulus table: direction, start address, length
  localparam int NV = 8;
  localparam bit V_WR   [NV] = '{0, 0, 0, 1, 1, 0, 1, 0};
  localparam int V_ADDR [NV] = '{'h0100, 'h0105, 'h0109, 'h0203, 'h020E, 'h0300, 'h0401, 'h05FF};
  localparam int V_LEN  [NV] = '{16, 5, 30, 13, 40, 64, 64, 1};

  function automatic logic [7:0] src_byte(input int a, input int k);
    return 8'(a * 3 + k * 11 + 5);
  endfunction
  function automatic logic [7:0] mem_byte(input int a);
    return 8'(a * 7 + (a >> 8) + 3);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic present(input bit wr, input int addr, input int len, input bit need);
    req_valid = 1; req_write = wr; req_need_rsp = need;
    req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
    req_wdata = '0;
    for (int k = 0; k < MAXL; k++)
      if (k < len) req_wdata[k*8 +: 8] = src_byte(addr, k);
  endtask

  function automatic logic [LW-1:0] mem_line(input int base);
    logic [LW-1:0] l;
    for (int b = 0; b < LINE; b++) l[b*8 +: 8] = mem_byte(base + b);
    return l;
  endfunction

  // Full transfer from request to response, walking addresses byte-range by byte-range.
  task automatic run_req(input bit wr, input int addr, input int len, input bit need);
    int cur, endp, done, clen, nb, bnd;
    present(wr, addr, len, need);
    step();
    req_valid = 0;
    chk("R1 accept", req_accept, 1);
    cur = addr; endp = addr + len; done = 0;
    while (cur < endp) begin
      bnd  = (cur / LINE + 1) * LINE;
      clen = ((endp < bnd) ? endp : bnd) - cur;
      chk(done == 0 ? "R3 valid" : "R6 valid", dn_valid, 1);
      chk(done == 0 ? "R3 addr" : "R4 addr", dn_addr, cur);
      chk(done == 0 ? "R3 len" : "R4 len", dn_len, clen);
      chk("R5 dir", dn_store, wr);
      if (wr) begin
        nb = 0;
        for (int b = 0; b < clen; b++)
          if (dn_wdata[((cur % LINE) + b)*8 +: 8] != src_byte(addr, done + b)) nb++;
        chk("R5 store bytes bad", nb, 0);
      end else begin
        cpl_data = mem_line(cur - (cur % LINE));
      end
      cpl_valid = 1;
      step();
      cpl_valid = 0;
      cur += clen; done += clen;
    end
    chk("R6 no more chunks", dn_valid, 0);
    chk("R9 not early", rsp_valid, 0);
    step();
    chk("R9 rsp", rsp_valid, need);
    if (need) begin
      chk("R9 dir", rsp_write, wr);
      if (!wr) begin
        nb = 0;
        for (int i = 0; i < len; i++)
          if (rsp_rdata[i*8 +: 8] != mem_byte(addr + i)) nb++;
        chk("R7 read bytes bad", nb, 0);
      end
    end
    step();
    chk("R9 one pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    drain_req = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 dn_valid", dn_valid, 0);
    chk("R12 rsp_valid", rsp_valid, 0);
    chk("R12 retry", retry, 0);
    chk("R12 status", {req_accept, req_full, req_badlen, drain_done}, 0);
    chk("R12 idle via drained", drained, 1);
    drain_req = 0;

    for (int v = 0; v < NV; v++) run_req(V_WR[v], V_ADDR[v], V_LEN[v], 1'b1);

    // R9: no response requested
    run_req(1'b1, 'h0610, 8, 1'b0);

    // R11: bad lengths
    present(1'b1, 'h0700, 0, 1'b1);
    step(); req_valid = 0;
    chk("R11 zero badlen", req_badlen, 1);
    chk("R11 zero no accept", req_accept, 0);
    chk("R11 zero no issue", dn_valid, 0);
    present(1'b0, 'h0700, MAXL + 1, 1'b1);
    step(); req_valid = 0;
    chk("R11 long badlen", req_badlen, 1);
    chk("R11 long no issue", dn_valid, 0);
    step();
    chk("R11 no retry", retry, 0);

    // R1/R2/R8: reject while busy, retry, immediate re-accept
    present(1'b0, 'h0044, 4, 1'b1);
    step(); req_valid = 0;
    chk("R1 first accepted", req_accept, 1);
    present(1'b1, 'h0080, 8, 1'b1);
    step(); req_valid = 0;
    chk("R1 full", req_full, 1);
    chk("R1 not accepted", req_accept, 0);
    chk("R1 not issued", dn_valid, 0);
    cpl_data = mem_line('h0040);
    cpl_valid = 1;
    step(); cpl_valid = 0;
    chk("R2 retry pulse", retry, 1);
    present(1'b1, 'h0080, 8, 1'b1);
    step(); req_valid = 0;
    chk("R8 retried accepted", req_accept, 1);
    chk("R8 retried issued", dn_valid, 1);
    chk("R8 retried addr", dn_addr, 'h0080);
    chk("R2 retry one pulse", retry, 0);
    chk("R9 first rsp", rsp_valid, 1);
    nb = 0;
    for (int i = 0; i < 4; i++) if (rsp_rdata[i*8 +: 8] != mem_byte('h0044 + i)) nb++;
    chk("R7 first rsp bytes bad", nb, 0);
    cpl_valid = 1;
    step(); cpl_valid = 0;
    chk("R2 cleared no retry", retry, 0);
    step();
    chk("R9 second rsp", rsp_valid, 1);
    step();

    // R10: drain
    drain_req = 1;
    #1 chk("R10 idle drained", drained, 1);
    present(1'b0, 'h0090, 4, 1'b0);
    step(); req_valid = 0;
    chk("R10 busy not drained", drained, 0);
    chk("R10 no early done", drain_done, 0);
    cpl_data = mem_line('h0090);
    cpl_valid = 1;
    step(); cpl_valid = 0;
    chk("R10 drain_done", drain_done, 1);
    chk("R10 drained", drained, 1);
    step();
    chk("R10 done one pulse", drain_done, 0);
    drain_req = 0;
    #1 chk("R10 no drain req", drained, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule